// File: doc/BRIEF.md
# Floating-Point Operand Test Unit

The unit takes one operand per handshake, in one of six source formats, and classifies it without altering it. Integer operands (8, 16 and 32 bit, two's complement) and IEEE binary floating-point operands (single, double, and the 80-bit extended form with an explicit integer bit) are first brought to a common extended-width view. That view is then reduced to a four-bit condition code that reports sign, zero, infinity and not-a-number.

Each accepted operand also updates a 24-bit status word that the unit holds. The exception byte is rewritten on every test, so only the signalling-NaN flag can survive. The accrued byte gathers an invalid-operation flag across tests. The quotient byte is left alone by tests and is written only through a dedicated load port, which the divide logic elsewhere drives. The result is held in a single output register with a valid/ready handshake, and a stalled consumer back-pressures the input.

Top module: `fpt_test_unit`

## Requirements
- R1: `in_ready_o` is high when the output register is empty or is being consumed in the same cycle. An operand accepted at a clock edge shows its condition code on `out_valid_o`/`out_cc_o` after that edge. While `out_valid_o` is high and `out_ready_i` is low, the output holds steady.
- R2: Format codes are 0 byte, 1 word, 2 long, 3 single, 4 double, 5 extended. Every format is right-aligned in `in_opnd_i`, and the bits above the format width are ignored.
- R3: The condition code is {N,Z,I,NAN} at bits 3..0. For integer formats N is the top bit and Z means all bits are zero. I and NAN are never set for integers.
- R4: A float with zero exponent and zero significand sets Z. A denormal, or an extended value with zero exponent and only a nonzero significand, sets neither Z, I nor NAN. In both cases N copies the sign bit.
- R5: A float with the exponent all ones and zero fraction sets I, with N from the sign. For the extended format, the explicit integer bit (bit 63) is ignored in this test.
- R6: A float with the exponent all ones and a nonzero fraction sets NAN, with N from the sign. Z, I and NAN are never set together.
- R7: A NaN is signalling when the top fraction bit (bit 22 single, bit 51 double, bit 62 extended) is 0. A signalling NaN sets status bit 14. A quiet NaN does not set it.
- R8: Each accepted operand rewrites the exception byte (status bits 15:8) to 8'h40 for a signalling NaN and to 8'h00 otherwise.
- R9: A signalling NaN ORs status bit 7 into the accrued byte (bits 7:0). Tests never clear any accrued bit.
- R10: Tests never change the quotient byte (bits 23:16). It is loaded from `quo_i` only in a cycle when `quo_we_i` is high.
- R11: Reset clears `out_valid_o`, `out_cc_o` and the whole status word.
- R12: The unused format codes 6 and 7 classify the low 32 bits as a long integer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand valid |
| in_ready_o | output | 1 | Unit can accept an operand |
| in_fmt_i | input | 3 | Source format code |
| in_opnd_i | input | 80 | Operand, right-aligned |
| quo_we_i | input | 1 | Load strobe for the quotient byte |
| quo_i | input | 8 | Quotient byte value to load |
| out_valid_o | output | 1 | Condition code valid |
| out_ready_i | input | 1 | Consumer takes the result |
| out_cc_o | output | 4 | {N, Z, I, NAN} |
| status_o | output | 24 | {quotient, exception, accrued} bytes |

## Verification
The bench builds the unit with the default field widths: 8/16/32-bit integers and 8/23, 11/52 and 15/63 exponent/fraction splits, with the extended form carrying its explicit integer bit. With these widths the bench can reach the pseudo-infinity and pseudo-denormal encodings. It can also reach signalling NaNs whose only set bit is the lowest fraction bit, and upper operand bits that a narrow format has to ignore. Back-pressure from the single output register is driven over several stalled cycles, with the next operand waiting at the input.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
  localparam int OPND_W     = 80;
  localparam int N_INT      = 3;
  localparam int INT_W [N_INT] = '{8, 16, 32};
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int EXT_EXP_W  = 15;
  localparam int EXT_FRAC_W = 63;
  localparam int MANT_W     = EXT_FRAC_W + 1;
  localparam int CC_W       = 4;
  localparam int STAT_W     = 24;

  localparam logic [2:0] FMT_BYTE = 3'd0;
  localparam logic [2:0] FMT_WORD = 3'd1;
  localparam logic [2:0] FMT_LONG = 3'd2;
  localparam logic [2:0] FMT_SGL  = 3'd3;
  localparam logic [2:0] FMT_DBL  = 3'd4;
  localparam logic [2:0] FMT_EXT  = 3'd5;

  localparam int CC_N   = 3;
  localparam int CC_Z   = 2;
  localparam int CC_I   = 1;
  localparam int CC_NAN = 0;

  localparam int EXC_SNAN_BIT = 6;
  localparam int ACC_IOP_BIT  = 7;

  typedef struct packed {
    logic              is_int;
    logic              sign;
    logic              int_zero;
    logic              exp_max;
    logic              exp_zero;
    logic [MANT_W-1:0] mant;
  } wide_t;
endpackage

// File: rtl/fpt_int_field.sv
module fpt_int_field
  import fpt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] raw_i,
  output wide_t        wide_o
);
  always_comb begin
    wide_o          = '0;
    wide_o.is_int   = 1'b1;
    wide_o.sign     = raw_i[W-1];
    wide_o.int_zero = (raw_i == '0);
  end
endmodule

// File: rtl/fpt_fp_field.sv
module fpt_fp_field
  import fpt_pkg::*;
#(
  parameter int EXP_W    = 8,
  parameter int FRAC_W   = 23,
  parameter bit EXPLICIT = 1'b0,
  localparam int W       = 1 + EXP_W + FRAC_W + (EXPLICIT ? 1 : 0)
) (
  input  logic [W-1:0] raw_i,
  output wide_t        wide_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [MANT_W-1:0] mant;

  assign exp_f = raw_i[W-2 -: EXP_W];

  generate
    if (EXPLICIT) begin : g_expl
      assign mant = raw_i[MANT_W-1:0];
    end else begin : g_impl
      // hidden bit made explicit, fraction left-aligned under it
      assign mant = {(exp_f != '0), raw_i[FRAC_W-1:0], {(MANT_W-1-FRAC_W){1'b0}}};
    end
  endgenerate

  always_comb begin
    wide_o          = '0;
    wide_o.sign     = raw_i[W-1];
    wide_o.exp_max  = &exp_f;
    wide_o.exp_zero = (exp_f == '0);
    wide_o.mant     = mant;
  end
endmodule

// File: rtl/fpt_widen.sv
module fpt_widen
  import fpt_pkg::*;
(
  input  logic [2:0]        fmt_i,
  input  logic [OPND_W-1:0] opnd_i,
  output wide_t             wide_o
);
  localparam int SGL_W = 1 + SGL_EXP_W + SGL_FRAC_W;
  localparam int DBL_W = 1 + DBL_EXP_W + DBL_FRAC_W;
  localparam int EXT_W = 1 + EXT_EXP_W + EXT_FRAC_W + 1;

  wide_t int_w [N_INT];
  wide_t sgl_w, dbl_w, ext_w;

  generate
    for (genvar gi = 0; gi < N_INT; gi++) begin : g_int
      fpt_int_field #(.W(INT_W[gi])) u_int (
        .raw_i (opnd_i[INT_W[gi]-1:0]),
        .wide_o(int_w[gi])
      );
    end
  endgenerate

  fpt_fp_field #(.EXP_W(SGL_EXP_W), .FRAC_W(SGL_FRAC_W), .EXPLICIT(1'b0)) u_sgl (
    .raw_i (opnd_i[SGL_W-1:0]),
    .wide_o(sgl_w)
  );
  fpt_fp_field #(.EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W), .EXPLICIT(1'b0)) u_dbl (
    .raw_i (opnd_i[DBL_W-1:0]),
    .wide_o(dbl_w)
  );
  fpt_fp_field #(.EXP_W(EXT_EXP_W), .FRAC_W(EXT_FRAC_W), .EXPLICIT(1'b1)) u_ext (
    .raw_i (opnd_i[EXT_W-1:0]),
    .wide_o(ext_w)
  );

  always_comb begin
    unique case (fmt_i)
      FMT_BYTE: wide_o = int_w[0];
      FMT_WORD: wide_o = int_w[1];
      FMT_SGL:  wide_o = sgl_w;
      FMT_DBL:  wide_o = dbl_w;
      FMT_EXT:  wide_o = ext_w;
      default:  wide_o = int_w[2];  // long and unused codes
    endcase
  end
endmodule

// File: rtl/fpt_classify.sv
module fpt_classify
  import fpt_pkg::*;
(
  input  wide_t           wide_i,
  output logic [CC_W-1:0] cc_o,
  output logic            snan_o
);
  logic frac_nz, is_nan, is_inf, is_zero;

  // integer bit (top of mant) never takes part in the special-value decision
  assign frac_nz = |wide_i.mant[MANT_W-2:0];
  assign is_nan  = !wide_i.is_int && wide_i.exp_max && frac_nz;
  assign is_inf  = !wide_i.is_int && wide_i.exp_max && !frac_nz;
  assign is_zero = wide_i.is_int ? wide_i.int_zero
                                 : (wide_i.exp_zero && wide_i.mant == '0);

  always_comb begin
    cc_o         = '0;
    cc_o[CC_N]   = wide_i.sign;
    cc_o[CC_Z]   = is_zero;
    cc_o[CC_I]   = is_inf;
    cc_o[CC_NAN] = is_nan;
  end

  assign snan_o = is_nan && !wide_i.mant[MANT_W-2];
endmodule

// File: rtl/fpt_status.sv
module fpt_status
  import fpt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              snan_i,
  input  logic              quo_we_i,
  input  logic [7:0]        quo_i,
  output logic [STAT_W-1:0] status_o
);
  logic [7:0] quo_q, exc_q, acc_q;
  logic [7:0] exc_d, acc_set;

  always_comb begin
    exc_d                = '0;
    exc_d[EXC_SNAN_BIT]  = snan_i;
    acc_set              = '0;
    acc_set[ACC_IOP_BIT] = snan_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q <= '0;
      exc_q <= '0;
      acc_q <= '0;
    end else begin
      if (quo_we_i) quo_q <= quo_i;
      if (upd_i) begin
        exc_q <= exc_d;
        acc_q <= acc_q | acc_set;
      end
    end
  end

  assign status_o = {quo_q, exc_q, acc_q};

  assert_exc_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (status_o[15:8] & 8'hBF) == 8'h00);
  assert_snan_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && snan_i) |=> status_o[14] && status_o[7]);
  assert_acc_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_o[7:0] & $past(status_o[7:0])) == $past(status_o[7:0]));
  assert_quo_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !quo_we_i |=> $stable(status_o[23:16]));
endmodule

// File: rtl/fpt_test_unit.sv
module fpt_test_unit
  import fpt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [2:0]        in_fmt_i,
  input  logic [OPND_W-1:0] in_opnd_i,
  input  logic              quo_we_i,
  input  logic [7:0]        quo_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [CC_W-1:0]   out_cc_o,
  output logic [STAT_W-1:0] status_o
);
  wide_t           wide;
  logic [CC_W-1:0] cc_d, cc_q;
  logic            snan, accept, valid_q;

  fpt_widen u_widen (
    .fmt_i (in_fmt_i),
    .opnd_i(in_opnd_i),
    .wide_o(wide)
  );

  fpt_classify u_class (
    .wide_i(wide),
    .cc_o  (cc_d),
    .snan_o(snan)
  );

  fpt_status u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (accept),
    .snan_i  (snan),
    .quo_we_i(quo_we_i),
    .quo_i   (quo_i),
    .status_o(status_o)
  );

  assign in_ready_o = !valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cc_q    <= '0;
    end else if (in_ready_o) begin
      valid_q <= in_valid_i;
      if (in_valid_i) cc_q <= cc_d;
    end
  end

  assign out_valid_o = valid_q;
  assign out_cc_o    = cc_q;

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_cc_o));
  assert_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);
  assert_int_cc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (in_fmt_i < FMT_SGL || in_fmt_i > FMT_EXT)) |=> out_cc_o[1:0] == 2'b00);
  assert_cc_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $onehot0(out_cc_o[2:0]));
endmodule

// File: tb/sim_fpt_test_unit.sv
module sim_fpt_test_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_fmt = '0;
  logic [79:0] in_opnd = '0;
  logic        quo_we = 1'b0;
  logic [7:0]  quo = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_cc;
  logic [23:0] status;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_quo = '0, m_exc = '0, m_acc = '0;

  always #10 clk = ~clk;

  fpt_test_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_fmt_i(in_fmt), .in_opnd_i(in_opnd), .quo_we_i(quo_we), .quo_i(quo),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_cc_o(out_cc),
    .status_o(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one operand through an idle unit; checks cc and the status word
  task automatic run_op(input string req, input logic [2:0] fmt, input logic [79:0] d,
                        input logic [3:0] exp_cc, input logic exp_snan);
    @(negedge clk);
    in_fmt = fmt; in_opnd = d; in_valid = 1'b1;
    chk({req, " ready"}, {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    m_exc = exp_snan ? 8'h40 : 8'h00;
    if (exp_snan) m_acc = m_acc | 8'h80;
    chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({req, " cc"}, {28'd0, out_cc}, {28'd0, exp_cc});
    chk({req, " status"}, {8'd0, status}, {8'd0, m_quo, m_exc, m_acc});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11 valid", {31'd0, out_valid}, 32'd0);
    chk("R11 cc", {28'd0, out_cc}, 32'd0);
    chk("R11 status", {8'd0, status}, 32'd0);
    chk("R1 ready idle", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_ints;
    run_op("R3 byte neg", 3'd0, 80'h80, 4'b1000, 1'b0);
    run_op("R2 byte upper ignored", 3'd0, 80'hFF00, 4'b0100, 1'b0);
    run_op("R3 word neg", 3'd1, 80'h1_8000, 4'b1000, 1'b0);
    run_op("R3 long pos", 3'd2, 80'h7FFF_FFFF, 4'b0000, 1'b0);
    run_op("R2 long upper ignored", 3'd2, 80'hFFFF_0000_0000, 4'b0100, 1'b0);
    run_op("R12 code6 neg", 3'd6, 80'h8000_0000, 4'b1000, 1'b0);
    run_op("R12 code7 zero", 3'd7, 80'h1_0000_0000, 4'b0100, 1'b0);
  endtask

  task automatic t_single;
    run_op("R4 sgl +0", 3'd3, 80'h0, 4'b0100, 1'b0);
    run_op("R4 sgl -0", 3'd3, 80'h8000_0000, 4'b1100, 1'b0);
    run_op("R4 sgl denorm", 3'd3, 80'h8000_0001, 4'b1000, 1'b0);
    run_op("R2 sgl normal", 3'd3, 80'hFFFF_3F80_0000, 4'b0000, 1'b0);
    run_op("R5 sgl -inf", 3'd3, 80'hFF80_0000, 4'b1010, 1'b0);
    run_op("R6 sgl qnan", 3'd3, 80'h7FC0_0000, 4'b0001, 1'b0);
    run_op("R7 sgl snan", 3'd3, 80'h7F80_0001, 4'b0001, 1'b1);
    run_op("R8 exc cleared", 3'd3, 80'h3F80_0000, 4'b0000, 1'b0);
  endtask

  task automatic t_double;
    run_op("R5 dbl +inf", 3'd4, 80'h7FF0_0000_0000_0000, 4'b0010, 1'b0);
    run_op("R7 dbl -snan", 3'd4, 80'hFFF0_0000_0000_0001, 4'b1001, 1'b1);
    run_op("R6 dbl qnan", 3'd4, 80'h7FF8_0000_0000_0000, 4'b0001, 1'b0);
    run_op("R4 dbl -0", 3'd4, 80'h8000_0000_0000_0000, 4'b1100, 1'b0);
  endtask

  task automatic t_ext;
    run_op("R5 ext inf", 3'd5, {16'h7FFF, 64'h8000_0000_0000_0000}, 4'b0010, 1'b0);
    run_op("R5 ext pseudo inf", 3'd5, {16'hFFFF, 64'h0}, 4'b1010, 1'b0);
    run_op("R6 ext qnan", 3'd5, {16'h7FFF, 64'hC000_0000_0000_0000}, 4'b0001, 1'b0);
    run_op("R7 ext snan", 3'd5, {16'h7FFF, 64'h8000_0000_0000_0001}, 4'b0001, 1'b1);
    run_op("R7 ext snan no int bit", 3'd5, {16'hFFFF, 64'h0000_0000_0000_0001}, 4'b1001, 1'b1);
    run_op("R4 ext zero", 3'd5, {16'h8000, 64'h0}, 4'b1100, 1'b0);
    run_op("R4 ext pseudo denorm", 3'd5, {16'h0000, 64'h8000_0000_0000_0000}, 4'b0000, 1'b0);
  endtask

  task automatic t_quotient;
    @(negedge clk);
    quo_we = 1'b1; quo = 8'hA5;
    @(negedge clk);
    quo_we = 1'b0; quo = 8'h00;
    m_quo = 8'hA5;
    chk("R10 load", {8'd0, status}, {8'd0, m_quo, m_exc, m_acc});
    run_op("R10 kept by snan test", 3'd3, 80'hFF80_0001, 4'b1001, 1'b1);
    run_op("R10 kept by int test", 3'd0, 80'h0, 4'b0100, 1'b0);
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    in_fmt = 3'd3; in_opnd = 80'h7F80_0000; in_valid = 1'b1;
    @(negedge clk);
    in_fmt = 3'd0; in_opnd = 80'h0;
    for (int i = 0; i < 3; i++) begin
      chk("R1 stall valid", {31'd0, out_valid}, 32'd1);
      chk("R1 stall cc", {28'd0, out_cc}, 32'h2);
      chk("R1 stall ready", {31'd0, in_ready}, 32'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    m_exc = 8'h00;
    chk("R1 next valid", {31'd0, out_valid}, 32'd1);
    chk("R1 next cc", {28'd0, out_cc}, 32'h4);
    chk("R1 next status", {8'd0, status}, {8'd0, m_quo, m_exc, m_acc});
    @(negedge clk);
    chk("R1 drained", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ints();
    t_single();
    t_double();
    t_ext();
    t_quotient();
    t_stall();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual timeout expected completion");
    finish_run();
  end
endmodule